// File: doc/BRIEF.md
# Shared-Prefix Carry Select Adder

This block is a purely combinational adder of two `WIDTH`-bit operands with a carry input and a carry output. Unlike a conventional carry select adder, it does not build two complete ripple adders and then pick one of two sum words. Instead, it forms one bitwise propagate word (XOR) and one bitwise generate word (AND). Two carry chains are fed from that shared pair. One chain assumes an incoming carry of zero and the other assumes an incoming carry of one, and each chain's first stage is simplified for its fixed assumption.

Because the carry-one chain dominates the carry-zero chain bit for bit, the real carry at each position needs only a single AND-OR term. That term is the zero-chain bit, ORed with the incoming carry ANDed with the one-chain bit. The sum is then the propagate word XORed with the selected carry word shifted up by one position, with the external carry in feeding bit 0. The block is meant to be placed wherever a wide addition with a late-arriving carry input is needed, for example in the reduction stages of a multiplier.

Top module: `carry_sel_adder`

## Requirements
- R1: For every pair of operands and either carry in, the concatenation {co, sum_o} equals a_i + b_i + ci as a WIDTH+1 bit unsigned value.
- R2: Bit 0 of sum_o equals a_i[0] XOR b_i[0] XOR ci.
- R3: When a_i XOR b_i is all ones and ci is 1, sum_o is all zeros and co is 1.
- R4: When a_i XOR b_i is all ones and ci is 0, sum_o is all ones and co is 0.
- R5: When bit WIDTH-1 of both operands is 1, co is 1 whatever ci is.
- R6: When both operands are zero, co is 0 and sum_o equals ci in bit 0 with zeros above.
- R7: For fixed operands, the result {co, sum_o} with ci = 1 is exactly one more, modulo 2^(WIDTH+1), than the result with ci = 0. Internally, every carry bit that the zero-assumed chain sets is also set by the one-assumed chain.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| ci | input | 1 | Carry in |
| sum_o | output | WIDTH | Sum bits |
| co | output | 1 | Carry out, the top bit of the selected carry word |

## Verification
The bench aims at the full-propagate pattern with both carry-in values. This is the one input where the incoming carry must travel through every stage. A selection term that drops the one-chain bit, or a carry-one chain with a wrong first stage, gives a sum off by a power of two and a lost carry out there. Paired vectors that differ only in carry in expose a swapped or inverted carry-in path, because the two results then fail to differ by exactly one. A generate in the top bit with carry in low, and all-zero operands with carry in high, catch a carry out taken from the wrong bit and a sum bit 0 that ignores carry in. Random operands catch an off-by-one shift of the carry word into the sum.

// File: rtl/csa_pkg.sv
package csa_pkg;
   localparam int CSA_MIN_WIDTH = 2;
   localparam int CSA_MAX_WIDTH = 256;
endpackage

// File: rtl/csa_half_gen.sv
module csa_half_gen #(
   parameter int WIDTH = 16
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   output logic [WIDTH-1:0] hs_o,
   output logic [WIDTH-1:0] hc_o
);
   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      assign hs_o[i] = a_i[i] ^ b_i[i];
      assign hc_o[i] = a_i[i] & b_i[i];
   end
endmodule

// File: rtl/csa_carry_gen.sv
module csa_carry_gen #(
   parameter int WIDTH    = 16,
   parameter bit FIXED_CI = 1'b0
) (
   input  logic [WIDTH-1:0] hs_i,
   input  logic [WIDTH-1:0] hc_i,
   output logic [WIDTH-1:0] fc_o
);
   // first stage specialised for the assumed incoming carry
   if (FIXED_CI == 1'b0) begin : g_first_zero
      assign fc_o[0] = hc_i[0];
   end else begin : g_first_one
      assign fc_o[0] = hc_i[0] | hs_i[0];
   end

   for (genvar i = 1; i < WIDTH; i++) begin : g_chain
      assign fc_o[i] = (fc_o[i-1] & hs_i[i]) | hc_i[i];
   end
endmodule

// File: rtl/csa_carry_sel.sv
module csa_carry_sel #(
   parameter int WIDTH = 16
) (
   input  logic [WIDTH-1:0] fc0_i,
   input  logic [WIDTH-1:0] fc1_i,
   input  logic             ci,
   output logic [WIDTH-1:0] c_o
);
   for (genvar i = 0; i < WIDTH; i++) begin : g_sel
      assign c_o[i] = fc0_i[i] | (ci & fc1_i[i]);
   end

   always_comb begin
      // R7
      dominance_chk: assert ((fc0_i & ~fc1_i) == '0)
         else $error("zero-assumed carry set where one-assumed carry is clear");
   end
endmodule

// File: rtl/csa_sum_gen.sv
module csa_sum_gen #(
   parameter int WIDTH = 16
) (
   input  logic [WIDTH-1:0] hs_i,
   input  logic [WIDTH-1:0] c_i,
   input  logic             ci,
   output logic [WIDTH-1:0] sum_o,
   output logic             co
);
   assign sum_o[0] = hs_i[0] ^ ci;
   for (genvar i = 1; i < WIDTH; i++) begin : g_sum
      assign sum_o[i] = hs_i[i] ^ c_i[i-1];
   end
   assign co = c_i[WIDTH-1];
endmodule

// File: rtl/carry_sel_adder.sv
module carry_sel_adder
   import csa_pkg::*;
#(
   parameter int WIDTH = 16
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   input  logic             ci,
   output logic [WIDTH-1:0] sum_o,
   output logic             co
);
   if (WIDTH < CSA_MIN_WIDTH || WIDTH > CSA_MAX_WIDTH) begin : g_width_bad
      $error("carry_sel_adder: WIDTH %0d out of range", WIDTH);
   end

   logic [WIDTH-1:0] hs;
   logic [WIDTH-1:0] hc;
   logic [WIDTH-1:0] fc0;
   logic [WIDTH-1:0] fc1;
   logic [WIDTH-1:0] csel;

   csa_half_gen #(.WIDTH(WIDTH)) u_half (
      .a_i (a_i),
      .b_i (b_i),
      .hs_o(hs),
      .hc_o(hc)
   );

   csa_carry_gen #(.WIDTH(WIDTH), .FIXED_CI(1'b0)) u_cg0 (
      .hs_i(hs),
      .hc_i(hc),
      .fc_o(fc0)
   );

   csa_carry_gen #(.WIDTH(WIDTH), .FIXED_CI(1'b1)) u_cg1 (
      .hs_i(hs),
      .hc_i(hc),
      .fc_o(fc1)
   );

   csa_carry_sel #(.WIDTH(WIDTH)) u_sel (
      .fc0_i(fc0),
      .fc1_i(fc1),
      .ci   (ci),
      .c_o  (csel)
   );

   csa_sum_gen #(.WIDTH(WIDTH)) u_sum (
      .hs_i (hs),
      .c_i  (csel),
      .ci   (ci),
      .sum_o(sum_o),
      .co   (co)
   );

   logic [WIDTH:0] chk_total;

   always_comb begin
      chk_total = {1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, ci};
      // R1
      total_chk: assert ({co, sum_o} == chk_total)
         else $error("result differs from arithmetic sum");
      // R3
      prop_one_chk: assert (!((&(a_i ^ b_i)) && ci) || (sum_o == '0 && co))
         else $error("full propagate with carry in 1 wrong");
      // R4
      prop_zero_chk: assert (!((&(a_i ^ b_i)) && !ci) || ((&sum_o) && !co))
         else $error("full propagate with carry in 0 wrong");
      // R5
      top_gen_chk: assert (!(a_i[WIDTH-1] && b_i[WIDTH-1]) || co)
         else $error("top generate lost carry out");
      // R6
      zero_ops_chk: assert (!(a_i == '0 && b_i == '0) ||
                            (!co && sum_o == {{(WIDTH-1){1'b0}}, ci}))
         else $error("zero operands wrong");
   end
endmodule

// File: tb/carry_sel_adder_tb.sv
module carry_sel_adder_tb;
   localparam int W = 16;

   typedef struct {
      logic [W-1:0] a;
      logic [W-1:0] b;
      logic         c;
      logic [W:0]   exp;
      string        tag;
      bit           pair_hi;
   } item_t;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic [W-1:0] a_i = '0;
   logic [W-1:0] b_i = '0;
   logic         ci  = 1'b0;
   logic [W-1:0] sum_o;
   logic         co;

   int checks = 0;
   int errors = 0;
   bit drv_done = 1'b0;
   bit finished = 1'b0;
   item_t q[$];
   logic [W:0] last_res = '0;

   always #4 clk = ~clk;

   carry_sel_adder #(.WIDTH(W)) u_dut (
      .a_i  (a_i),
      .b_i  (b_i),
      .ci   (ci),
      .sum_o(sum_o),
      .co   (co)
   );

   task automatic drive(input logic [W-1:0] a, input logic [W-1:0] b,
                        input logic c, input string tag, input bit pair_hi);
      item_t it;
      @(posedge clk);
      a_i = a; b_i = b; ci = c;
      it.a = a; it.b = b; it.c = c;
      it.exp = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, c};
      it.tag = tag;
      it.pair_hi = pair_hi;
      q.push_back(it);
   endtask

   task automatic check(input string tag, input logic [W:0] act, input logic [W:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: a=%h b=%h ci=%b actual=%h expected=%h",
                  tag, a_i, b_i, ci, act, exp);
      end
   endtask

   // monitor: compare away from the driving edge
   always @(negedge clk) begin
      if (q.size() > 0) begin
         item_t it;
         logic [W:0] res;
         it = q.pop_front();
         res = {co, sum_o};
         check(it.tag, res, it.exp);
         if (it.tag == "R2")
            check("R2 bit0", {{W{1'b0}}, sum_o[0]}, {{W{1'b0}}, it.a[0] ^ it.b[0] ^ it.c});
         if (it.tag == "R5")
            check("R5 co", {{W{1'b0}}, co}, {{W{1'b0}}, 1'b1});
         if (it.pair_hi)
            check("R7 pair", res, last_res + 1'b1);
         last_res = res;
      end
   end

   initial begin
      repeat (2) @(posedge clk);
      rst = 1'b0;
      // R6 reset-time state: zero operands
      drive('0, '0, 1'b0, "R6", 1'b0);
      drive('0, '0, 1'b1, "R6", 1'b0);
      // R3, R4 full propagate
      drive(16'hAAAA, 16'h5555, 1'b0, "R4", 1'b0);
      drive(16'hAAAA, 16'h5555, 1'b1, "R3", 1'b1);
      drive(16'hFFFF, 16'h0000, 1'b1, "R3", 1'b0);
      drive(16'h0F0F, 16'hF0F0, 1'b0, "R4", 1'b0);
      // R5 top bit generate
      drive(16'h8000, 16'h8000, 1'b0, "R5", 1'b0);
      drive(16'hFFFF, 16'hFFFF, 1'b1, "R5", 1'b0);
      drive(16'h8001, 16'hC000, 1'b0, "R5", 1'b0);
      // R2 bit 0 cases
      drive(16'h0001, 16'h0000, 1'b1, "R2", 1'b0);
      drive(16'h0001, 16'h0001, 1'b1, "R2", 1'b0);
      drive(16'h1234, 16'h4320, 1'b1, "R2", 1'b0);
      // R7 paired vectors and R1 random
      for (int k = 0; k < 40; k++) begin
         logic [W-1:0] ra, rb;
         ra = W'($urandom);
         rb = W'($urandom);
         drive(ra, rb, 1'b0, "R1", 1'b0);
         drive(ra, rb, 1'b1, "R7", 1'b1);
      end
      for (int k = 0; k < 40; k++)
         drive(W'($urandom), W'($urandom), 1'($urandom), "R1", 1'b0);
      @(posedge clk);
      @(posedge clk);
      drv_done = 1'b1;
   end

   initial begin
      int cyc = 0;
      while (!drv_done && cyc < 5000) begin
         @(posedge clk);
         cyc++;
      end
      if (!drv_done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
      end
      @(posedge clk);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      finished = 1'b1;
      $finish;
   end
endmodule